// File: doc/BRIEF.md
# Halfword-Splicing Instruction Fetch Buffer

This block sits between a core's program counter and an instruction cache that can only return aligned 32-bit words. The core runs a mixed stream of 16-bit (short) and 32-bit (long) instructions, so the PC is often only halfword aligned. Each cycle the block turns the PC into the aligned word address that holds the needed bits. It keeps a spare upper halfword in a one-entry holding slot, and it splices the slot and the fetched word into one instruction. That instruction goes to the decompressor together with a flag that gives its length.

The control is a Mealy machine. Its state is the PC halfword bit together with the slot's valid bit. Outputs follow the current inputs within the same cycle, and the slot is updated at the next rising edge. The core owns the PC. When an instruction is reported valid, the core advances the PC by 2 or 4 bytes as the length flag says. Otherwise it holds the PC. A redirect input flags a branch or jump, and it discards the slot in the same cycle.

Top module: `fetch_buffer`

## Requirements
- R1: After reset the holding slot is empty, and no instruction is reported valid until the cache returns data.
- R2: The cache address always has its two low bits clear. It is the word containing the PC, except when the slot holds the low half of a long instruction. In that case it is PC+2.
- R3: A halfword is short when its low two bits are not 2'b11. With an aligned PC and a short low half, the block delivers {16'h0, low half} as short and keeps the upper half in the slot.
- R4: With an aligned PC and a long low half, the block delivers the whole fetched word as long, and the slot stays empty.
- R5: With a halfword PC and a short halfword in the slot, that halfword is delivered as short with no cache request (ic_req_o = 0), and the slot becomes empty.
- R6: With a halfword PC and a long low half in the slot, the block fetches PC+2. It delivers {fetched low half, slot} as long and keeps the fetched upper half in the slot.
- R7: At a halfword PC with an empty slot, a short upper half of the fetched word is delivered alone, and the slot stays empty.
- R8: At a halfword PC with an empty slot, a long upper half is kept in the slot, and no instruction is reported in that cycle.
- R9: While the cache is not ready and a request is outstanding, no instruction is reported valid and the slot is held.
- R10: During a redirect the slot is ignored and cleared in the same cycle, so the new target is fetched from the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | ADDR_W | Address of the next instruction |
| redirect_i | input | 1 | Branch or jump this cycle; pc_i is the new target |
| ic_addr_o | output | ADDR_W | Word-aligned cache read address |
| ic_req_o | output | 1 | Cache data needed this cycle |
| ic_ready_i | input | 1 | Cache returns valid data this cycle |
| ic_rdata_i | input | 2*PARCEL_W | Fetched word |
| instr_o | output | 2*PARCEL_W | Assembled instruction (short ones zero-extended) |
| instr_valid_o | output | 1 | instr_o holds an instruction |
| instr_short_o | output | 1 | 1 for a 16-bit instruction, 0 for 32-bit |

## Verification
Address, request, instruction, valid and length flag are all combinational in the current PC, redirect, cache data and slot state. They are therefore due in the same cycle as the stimulus. The slot change caused by a cycle first shows in the outputs of the following cycle. The bench drives inputs on the falling edge and compares outputs 4 ns later, ahead of the rising edge. A requirement about slot contents is checked through the outputs of the next step: whether a cache request appears, and which halves get spliced together.

// File: rtl/fb_pkg.sv
package fb_pkg;

  // state = {pc halfword bit, effective slot valid}
  typedef enum logic [1:0] {
    FB_ALIGN_EMPTY = 2'b00,
    FB_ALIGN_HELD  = 2'b01,
    FB_HALF_EMPTY  = 2'b10,
    FB_HALF_HELD   = 2'b11
  } fb_state_e;

  // a parcel is short unless its two low bits are both set
  function automatic logic parcel_is_short(input logic [1:0] low_bits);
    return low_bits != 2'b11;
  endfunction

endpackage

// File: rtl/fb_rst_sync.sv
module fb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen
  import fb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PARCEL_W = 16
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  fb_state_e         state_i,
  input  logic              slot_short_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              req_o
);
  localparam int PARCEL_BYTES = PARCEL_W / 8;
  localparam int WORD_OFF     = $clog2(2 * PARCEL_BYTES);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << WORD_OFF) - 1);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(PARCEL_BYTES);

  logic [ADDR_W-1:0] pc_word;
  logic [ADDR_W-1:0] next_word;

  always_comb begin
    pc_word   = pc_i & ~OFF_MASK;
    next_word = (pc_i + STEP) & ~OFF_MASK;
  end

  always_comb begin
    addr_o = pc_word;
    req_o  = 1'b1;
    unique case (state_i)
      FB_HALF_HELD: begin
        addr_o = next_word;
        req_o  = !slot_short_i;
      end
      default: begin
        addr_o = pc_word;
        req_o  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fb_splicer.sv
module fb_splicer
  import fb_pkg::*;
#(
  parameter int PARCEL_W = 16
) (
  input  fb_state_e               state_i,
  input  logic                    ready_i,
  input  logic [2*PARCEL_W-1:0]   rdata_i,
  input  logic [PARCEL_W-1:0]     slot_i,
  output logic [2*PARCEL_W-1:0]   instr_o,
  output logic                    valid_o,
  output logic                    short_o,
  output logic                    slot_valid_d_o,
  output logic                    slot_load_o,
  output logic [PARCEL_W-1:0]     slot_data_o
);
  localparam int WORD_W = 2 * PARCEL_W;

  logic [PARCEL_W-1:0] lo_half;
  logic [PARCEL_W-1:0] hi_half;
  logic                lo_short;
  logic                hi_short;
  logic                slot_short;

  always_comb begin
    lo_half    = rdata_i[PARCEL_W-1:0];
    hi_half    = rdata_i[WORD_W-1:PARCEL_W];
    lo_short   = parcel_is_short(lo_half[1:0]);
    hi_short   = parcel_is_short(hi_half[1:0]);
    slot_short = parcel_is_short(slot_i[1:0]);
  end

  always_comb begin
    instr_o        = '0;
    valid_o        = 1'b0;
    short_o        = 1'b0;
    slot_valid_d_o = 1'b0;
    slot_load_o    = 1'b0;
    slot_data_o    = hi_half;
    unique case (state_i)
      FB_ALIGN_EMPTY, FB_ALIGN_HELD: begin
        // held slot with aligned PC cannot occur; it is handled as empty
        slot_valid_d_o = (state_i == FB_ALIGN_HELD);
        if (ready_i) begin
          valid_o = 1'b1;
          if (lo_short) begin
            instr_o        = {{PARCEL_W{1'b0}}, lo_half};
            short_o        = 1'b1;
            slot_load_o    = 1'b1;
            slot_valid_d_o = 1'b1;
          end else begin
            instr_o        = rdata_i;
            slot_valid_d_o = 1'b0;
          end
        end
      end
      FB_HALF_EMPTY: begin
        if (ready_i) begin
          if (hi_short) begin
            valid_o = 1'b1;
            short_o = 1'b1;
            instr_o = {{PARCEL_W{1'b0}}, hi_half};
          end else begin
            slot_load_o    = 1'b1;
            slot_valid_d_o = 1'b1;
          end
        end
      end
      FB_HALF_HELD: begin
        if (slot_short) begin
          valid_o = 1'b1;
          short_o = 1'b1;
          instr_o = {{PARCEL_W{1'b0}}, slot_i};
        end else begin
          slot_valid_d_o = 1'b1;
          if (ready_i) begin
            valid_o     = 1'b1;
            instr_o     = {lo_half, slot_i};
            slot_load_o = 1'b1;
          end
        end
      end
      default: begin
        valid_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fb_slot.sv
module fb_slot #(
  parameter int PARCEL_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_d_i,
  input  logic                load_i,
  input  logic [PARCEL_W-1:0] data_i,
  output logic                valid_q_o,
  output logic [PARCEL_W-1:0] data_q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q_o <= 1'b0;
    else        valid_q_o <= valid_d_i;
  end

  // payload is only read while valid_q_o is set, so it carries no reset
  always_ff @(posedge clk) begin
    if (load_i) data_q_o <= data_i;
  end
endmodule

// File: rtl/fetch_buffer.sv
module fetch_buffer
  import fb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PARCEL_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     pc_i,
  input  logic                  redirect_i,
  output logic [ADDR_W-1:0]     ic_addr_o,
  output logic                  ic_req_o,
  input  logic                  ic_ready_i,
  input  logic [2*PARCEL_W-1:0] ic_rdata_i,
  output logic [2*PARCEL_W-1:0] instr_o,
  output logic                  instr_valid_o,
  output logic                  instr_short_o
);
  localparam int HALF_BIT = $clog2(PARCEL_W / 8);

  logic                rst_sync_n;
  logic                fb_valid_q;
  logic [PARCEL_W-1:0] fb_data_q;
  logic                slot_eff;
  fb_state_e           state;
  logic                valid_d;
  logic                load_en;
  logic [PARCEL_W-1:0] load_data;

  fb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    slot_eff = fb_valid_q && !redirect_i;
    state    = fb_state_e'({pc_i[HALF_BIT], slot_eff});
  end

  fb_addr_gen #(.ADDR_W(ADDR_W), .PARCEL_W(PARCEL_W)) u_addr (
    .pc_i         (pc_i),
    .state_i      (state),
    .slot_short_i (parcel_is_short(fb_data_q[1:0])),
    .addr_o       (ic_addr_o),
    .req_o        (ic_req_o)
  );

  fb_splicer #(.PARCEL_W(PARCEL_W)) u_splice (
    .state_i        (state),
    .ready_i        (ic_ready_i),
    .rdata_i        (ic_rdata_i),
    .slot_i         (fb_data_q),
    .instr_o        (instr_o),
    .valid_o        (instr_valid_o),
    .short_o        (instr_short_o),
    .slot_valid_d_o (valid_d),
    .slot_load_o    (load_en),
    .slot_data_o    (load_data)
  );

  fb_slot #(.PARCEL_W(PARCEL_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .valid_d_i (valid_d),
    .load_i    (load_en),
    .data_i    (load_data),
    .valid_q_o (fb_valid_q),
    .data_q_o  (fb_data_q)
  );
endmodule

// File: rtl/fb_checker.sv
module fb_checker #(
  parameter int ADDR_W   = 32,
  parameter int PARCEL_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   pc_i,
  input logic                redirect_i,
  input logic [ADDR_W-1:0]   ic_addr_o,
  input logic                ic_req_o,
  input logic                ic_ready_i,
  input logic                instr_valid_o,
  input logic                instr_short_o,
  input logic                fb_valid_q,
  input logic [PARCEL_W-1:0] fb_data_q
);
  localparam int HALF_BIT = $clog2(PARCEL_W / 8);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PARCEL_W / 8);

  // R2
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ic_req_o |-> ic_addr_o[1:0] == 2'b00);

  // R9
  stall_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_req_o && !ic_ready_i) |-> !instr_valid_o);

  // R9
  stall_holds_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_req_o && !ic_ready_i && !redirect_i) |=> ($stable(fb_valid_q) && (!fb_valid_q || $stable(fb_data_q))));

  // R10
  redirect_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_i && !ic_ready_i) |=> !fb_valid_q);

  // R3
  short_aligned_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_o && instr_short_o && !pc_i[HALF_BIT]) |=> fb_valid_q);

  // R4
  long_aligned_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_o && !instr_short_o && !pc_i[HALF_BIT]) |=> !fb_valid_q);

  // R5
  no_req_means_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ic_req_o |-> (instr_valid_o && instr_short_o));

  // R6
  splice_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_o && !instr_short_o && pc_i[HALF_BIT]) |-> ic_addr_o == pc_i + STEP);
endmodule

bind fetch_buffer fb_checker #(.ADDR_W(ADDR_W), .PARCEL_W(PARCEL_W)) u_fb_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pc_i          (pc_i),
  .redirect_i    (redirect_i),
  .ic_addr_o     (ic_addr_o),
  .ic_req_o      (ic_req_o),
  .ic_ready_i    (ic_ready_i),
  .instr_valid_o (instr_valid_o),
  .instr_short_o (instr_short_o),
  .fb_valid_q    (fb_valid_q),
  .fb_data_q     (fb_data_q)
);

// File: tb/tb_fetch_buffer.sv
module tb_fetch_buffer;
  logic        clk;
  logic        rst_n;
  logic [31:0] pc;
  logic        redirect;
  logic [31:0] ic_addr;
  logic        ic_req;
  logic        ic_ready;
  logic [31:0] ic_rdata;
  logic [31:0] instr;
  logic        instr_valid;
  logic        instr_short;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  typedef struct {
    bit          ev;
    logic [31:0] ei;
    bit          es;
    bit          ereq;
    logic [31:0] ea;
    string       tag;
  } exp_t;

  exp_t sb[$];

  fetch_buffer dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .redirect_i(redirect),
    .ic_addr_o(ic_addr), .ic_req_o(ic_req), .ic_ready_i(ic_ready),
    .ic_rdata_i(ic_rdata), .instr_o(instr), .instr_valid_o(instr_valid),
    .instr_short_o(instr_short)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // driver: applies one cycle of stimulus and queues what must appear
  task automatic step(input logic [31:0] p, input bit rd, input bit rdy,
                      input logic [31:0] data, input bit ev, input logic [31:0] ei,
                      input bit es, input bit ereq, input logic [31:0] ea,
                      input string tag);
    exp_t e;
    @(negedge clk);
    pc = p; redirect = rd; ic_ready = rdy; ic_rdata = data;
    e.ev = ev; e.ei = ei; e.es = es; e.ereq = ereq; e.ea = ea; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares outputs shortly before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (sb.size() > 0) begin
        exp_t e;
        bit bad;
        e = sb.pop_front();
        bad = (instr_valid !== e.ev) || (ic_req !== e.ereq);
        if (e.ev && ((instr !== e.ei) || (instr_short !== e.es))) bad = 1;
        if (e.ereq && (ic_addr !== e.ea)) bad = 1;
        n_checks++;
        if (bad) begin
          n_fails++;
          $display("FAIL %s: got valid=%0b instr=%h short=%0b req=%0b addr=%h; expected valid=%0b instr=%h short=%0b req=%0b addr=%h",
                   e.tag, instr_valid, instr, instr_short, ic_req, ic_addr,
                   e.ev, e.ei, e.es, e.ereq, e.ea);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pc = 32'h2; redirect = 0; ic_ready = 0; ic_rdata = '0;
    repeat (3) @(posedge clk);
    // R1: in reset the slot is empty, halfword pc asks the cache
    step(32'h2, 0, 0, 32'h0, 0, 32'h0, 0, 1, 32'h0, "R1 in reset");
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    step(32'h0, 0, 0, 32'h0, 0, 32'h0, 0, 1, 32'h0, "R1 after reset");
    // R4 long aligned
    step(32'h100, 0, 1, 32'h00A00093, 1, 32'h00A00093, 0, 1, 32'h100, "R4 long aligned");
    // R3 short aligned, upper kept
    step(32'h104, 0, 1, 32'h05054501, 1, 32'h00004501, 1, 1, 32'h104, "R3 short aligned");
    // R5 slot delivers without cache
    step(32'h106, 0, 0, 32'hDEADBEEF, 1, 32'h00000505, 1, 0, 32'h0, "R5 slot short");
    step(32'h108, 0, 1, 32'h00934501, 1, 32'h00004501, 1, 1, 32'h108, "R3 short then long low kept");
    // R9 stall with long low half in slot; R2 address pc+2
    step(32'h10A, 0, 0, 32'h0, 0, 32'h0, 0, 1, 32'h10C, "R9 stall R2 addr");
    step(32'h10A, 0, 0, 32'h0, 0, 32'h0, 0, 1, 32'h10C, "R9 stall held");
    // R6 splice
    step(32'h10A, 0, 1, 32'h050500A0, 1, 32'h00A00093, 0, 1, 32'h10C, "R6 splice");
    step(32'h10E, 0, 0, 32'h0, 1, 32'h00000505, 1, 0, 32'h0, "R6 upper kept");
    // R3 encoding: low bits 10 and 00 are short
    step(32'h110, 0, 1, 32'h45018082, 1, 32'h00008082, 1, 1, 32'h110, "R3 low bits 10");
    step(32'h112, 0, 0, 32'h0, 1, 32'h00004501, 1, 0, 32'h0, "R5 second");
    step(32'h114, 0, 1, 32'h00934000, 1, 32'h00004000, 1, 1, 32'h114, "R3 low bits 00");
    // R7 jump to halfword short (slot held 0093 is discarded by redirect)
    step(32'h202, 1, 1, 32'h45011234, 1, 32'h00004501, 1, 1, 32'h200, "R7 half short");
    step(32'h204, 0, 0, 32'h0, 0, 32'h0, 0, 1, 32'h204, "R7 slot empty");
    // R8 jump to halfword long
    step(32'h302, 1, 1, 32'h00935555, 0, 32'h0, 0, 1, 32'h300, "R8 half long");
    step(32'h302, 0, 1, 32'h450100A0, 1, 32'h00A00093, 0, 1, 32'h304, "R8 then R6");
    step(32'h306, 0, 0, 32'h0, 1, 32'h00004501, 1, 0, 32'h0, "R8 tail");
    // R10 redirect ignores slot
    step(32'h400, 0, 1, 32'h05054501, 1, 32'h00004501, 1, 1, 32'h400, "R10 setup");
    step(32'h500, 1, 1, 32'h00A00093, 1, 32'h00A00093, 0, 1, 32'h500, "R10 aligned target");
    step(32'h600, 0, 1, 32'h05054501, 1, 32'h00004501, 1, 1, 32'h600, "R10 setup2");
    step(32'h702, 1, 0, 32'h0, 0, 32'h0, 0, 1, 32'h700, "R10 half target");
    step(32'h702, 0, 0, 32'h0, 0, 32'h0, 0, 1, 32'h700, "R10 slot cleared");
    repeat (2) @(negedge clk);
    #6;
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule